// File: doc/BRIEF.md
# Legacy INTx Pending and Enable Register

This block gathers the four level-sensitive legacy interrupt lines of a host bridge (INTA through INTD) into one 32-bit control word. It produces one combined interrupt request toward a parent interrupt controller. The same word also holds the enable bits for a group of bus-error reports, which are produced and consumed elsewhere.

Software reaches the word through a single-address port with byte-lane strobes. A read returns the current word. The upper nibble holds the pending flags, one per line, and software clears them by writing ones there. Four enable bits in the same word choose which pending lines may raise the combined request. The error-report enables are kept as plain storage.

Writing zeros into the pending nibble leaves pending lines untouched, so software can update an enable bit with a read-modify-write that writes the pending field back as zero. A single halfword write of 0xF000 to the upper half both clears every pending flag and masks every line.

Top module: `intx_ctl`

## Requirements
- R1: After reset the whole word reads 0x00000000, meaning nothing is pending and every line is masked, and `irqOut` is low.
- R2: Pending flags sit at bits 31:28, with INTA at bit 28, INTB at 29, INTC at 30 and INTD at 31. A flag becomes 1 at the clock edge at which its `intxLine` input is high, whatever its enable bit holds. It stays 1 after the line drops.
- R3: A write with lane strobe 3 (bits 31:24) active clears each pending flag whose data bit is 1. A data bit of 0 leaves that flag as it was.
- R4: If a line is high in the same cycle that its flag is written with 1, the flag ends up as 1: setting wins over clearing.
- R5: Enable bits sit at bits 25:22, with INTA at bit 22 and INTD at bit 25. They are read/write, and a 1 lets the line drive the request. Bits 25:24 belong to lane 3 and bits 23:22 to lane 2.
- R6: `irqOut` is 1 in the cycle after the edge at which some pending flag and its enable bit are both 1. It is 0 in the cycle after an edge at which no such pair exists.
- R7: The error-report enables are plain read/write bits at 27:26 (lane 3) and 21:16 (lane 2).
- R8: Bits 15:0 always read as 0, and writes to them are ignored.
- R9: A write with lane strobes 3 and 2 and data 0xF0000000 clears every pending flag and every enable bit, provided no line is high, and leaves the word at 0x00000000.
- R10: A bit in a lane whose strobe is 0 keeps its value when the word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for the control word |
| wrStrb | input | 4 | Byte-lane strobes, bit n covers data bits 8n+7:8n |
| wrData | input | 32 | Write data |
| intxLine | input | 4 | Level interrupt lines, bit 0 is INTA, bit 3 is INTD |
| rdData | output | 32 | Current control word |
| irqOut | output | 1 | Combined request to the parent controller |

## Verification
The lines are driven singly, together, and while masked. This separates the flag setting, which ignores the enables, from the request output, which depends on them, and it also shows the one-cycle lag of the request.

Clears are tried with all-zero data, with a single one bit, and against a line that is held high. These cases tell the write-one-to-clear behaviour apart from a plain store and show that setting wins over clearing.

Partial-strobe writes, all-ones writes and the 0xF000 halfword write cover lane isolation, the bits that always read zero, and the combined mask-and-clear.

// File: rtl/intx_ctl_pkg.sv
package intx_ctl_pkg;
  localparam int WORD_W   = 32;
  localparam int LANES    = WORD_W / 8;
  localparam int NLINES   = 4;
  localparam int STS_LSB  = 28;
  localparam int ENA_LSB  = 22;
  // read/write storage: error enables 27:26 and 21:16, line enables 25:22
  localparam logic [WORD_W-1:0] RW_BITS = 32'h0FFF_0000;

  typedef struct packed {
    logic [LANES-1:0]  laneWe;
    logic [NLINES-1:0] stsClr;
    logic [WORD_W-1:0] data;
  } wrStb_t;
endpackage

// File: rtl/intx_ctl_decode.sv
module intx_ctl_decode
  import intx_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [LANES-1:0]  wrStrb,
  input  logic [WORD_W-1:0] wrData,
  output wrStb_t            stb
);
  localparam int STS_LANE = STS_LSB / 8;

  always_comb begin
    stb.laneWe = wrEn ? wrStrb : '0;
    stb.data   = wrData;
    stb.stsClr = (wrEn && wrStrb[STS_LANE]) ? wrData[STS_LSB +: NLINES] : '0;
  end
endmodule

// File: rtl/intx_ctl_regs.sv
module intx_ctl_regs
  import intx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStb_t            stb,
  input  logic [NLINES-1:0] intxLine,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  logic [WORD_W-1:0] rwReg;
  logic [NLINES-1:0] sts;
  logic [NLINES-1:0] ena;
  logic              irqQ;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rwReg[8*b +: 8] <= '0;
      else if (stb.laneWe[b])
        rwReg[8*b +: 8] <= stb.data[8*b +: 8] & RW_BITS[8*b +: 8];
    end
  end

  assign ena = rwReg[ENA_LSB +: NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sts[i] <= 1'b0;
      else if (intxLine[i])
        sts[i] <= 1'b1;
      else if (stb.stsClr[i])
        sts[i] <= 1'b0;
    end

    // R2 / R4: a high line always leaves its flag set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      intxLine[i] |=> rdData[STS_LSB+i]);
    // R3: a clear with the line idle drops the flag
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
      (stb.stsClr[i] && !intxLine[i]) |=> !rdData[STS_LSB+i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(sts & ena);
  end

  always_comb begin
    rdData = rwReg;
    rdData[STS_LSB +: NLINES] = sts;
  end
  assign irqOut = irqQ;

  // R6: request follows an enabled pending line one cycle later
  a_r6_irq_low: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[STS_LSB +: NLINES] & rdData[ENA_LSB +: NLINES]) == '0) |=> !irqOut);
  a_r6_irq_high: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[STS_LSB +: NLINES] & rdData[ENA_LSB +: NLINES]) != '0) |=> irqOut);
  // R10: enables keep their value without a write on their lanes
  a_r10_ena_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneWe[3:2] == 2'b00) |=> $stable(rdData[ENA_LSB +: NLINES]));
  // R3: a flag never rises while its line is idle
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (intxLine == '0) |=> ((rdData[STS_LSB +: NLINES] & ~$past(rdData[STS_LSB +: NLINES])) == '0));
endmodule

// File: rtl/intx_ctl.sv
module intx_ctl
  import intx_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrStrb,
  input  logic [31:0] wrData,
  input  logic [3:0]  intxLine,
  output logic [31:0] rdData,
  output logic        irqOut
);
  wrStb_t stb;

  intx_ctl_decode u_decode (
    .wrEn   (wrEn),
    .wrStrb (wrStrb),
    .wrData (wrData),
    .stb    (stb)
  );

  intx_ctl_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .intxLine (intxLine),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/intx_ctl_test.sv
module intx_ctl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrStrb = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  intxLine = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] expRd;
    logic        expIrq;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [31:0] mWord = '0;

  always #5 clk = ~clk;

  intx_ctl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb),
    .wrData(wrData), .intxLine(intxLine), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic op(input logic we, input logic [3:0] strb, input logic [31:0] data,
                    input logic [3:0] line, input string tag);
    logic [31:0] laneBits;
    logic [31:0] rw;
    logic [3:0]  sts;
    logic        expIrq;
    item_t       it;
    @(negedge clk);
    wrEn = we; wrStrb = strb; wrData = data; intxLine = line;
    expIrq = |(mWord[31:28] & mWord[25:22]);
    laneBits = {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
    rw = 32'h0FFF_0000;
    sts = mWord[31:28];
    if (we) begin
      mWord = (mWord & ~(rw & laneBits)) | (data & rw & laneBits);
      if (strb[3]) sts = sts & ~data[31:28];
    end
    sts = sts | line;
    mWord[31:28] = sts;
    @(posedge clk);
    it.expRd = mWord; it.expIrq = expIrq; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        nChecks++;
        if (rdData !== it.expRd || irqOut !== it.expIrq) begin
          nFails++;
          $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                   it.tag, rdData, irqOut, it.expRd, it.expIrq);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (rdData !== 32'h0 || irqOut !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: rdData=%h irq=%b expected 00000000 0", rdData, irqOut);
    end
    rstN = 1'b1;
    op(0, 4'h0, 32'h0, 4'h0, "R1 idle after reset");
    op(0, 4'h0, 32'h0, 4'b0001, "R2 INTA sets while masked");
    op(0, 4'h0, 32'h0, 4'b0000, "R2 flag held, R6 masked no irq");
    op(1, 4'h4, 32'h00C0_0000, 4'h0, "R5 enable INTA/INTB via lane 2");
    op(0, 4'h0, 32'h0, 4'h0, "R6 irq rises after enable");
    op(1, 4'h8, 32'h0000_0000, 4'h0, "R3 zero write keeps flag");
    op(0, 4'h0, 32'h0, 4'b1010, "R2 INTB and INTD set");
    op(1, 4'h8, 32'h1000_0000, 4'h0, "R3 clear INTA only");
    op(0, 4'h0, 32'h0, 4'h0, "R6 INTB still enabled");
    op(1, 4'h8, 32'hA000_0000, 4'b0010, "R4 set beats clear on INTB");
    op(1, 4'h8, 32'h2000_0000, 4'h0, "R3 clear INTB");
    op(0, 4'h0, 32'h0, 4'h0, "R6 irq falls");
    op(1, 4'hF, 32'hFFFF_FFFF, 4'h0, "R7 R8 all-ones write");
    op(1, 4'h3, 32'h0000_FFFF, 4'h0, "R8 R10 low lanes only");
    op(1, 4'h4, 32'h0000_0000, 4'h0, "R10 lane 2 cleared, lane 3 kept");
    op(0, 4'h0, 32'h0, 4'b0100, "R2 INTC sets");
    op(1, 4'h8, 32'h0C00_0000, 4'h0, "R7 error enables 27:26");
    op(1, 4'hC, 32'hF000_0000, 4'h0, "R9 mask and clear all");
    op(0, 4'h0, 32'h0, 4'b1111, "R2 all lines set while masked");
    op(1, 4'hC, 32'hF000_0000, 4'h0, "R9 second clear");
    op(0, 4'h0, 32'h0, 4'h0, "R9 word zero, irq low");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule